// File: doc/BRIEF.md
# Sub-word Load/Store Lane Aligner

This block sits between a 32-bit processor pipeline and a data memory that is organised in whole words. It deals with the byte, halfword and word forms of load and store. The pipeline forms an effective address from a base register plus a sign-extended 16-bit offset. Only the two low bits of that sum reach this block. For a store it also receives the source register, and for a load it receives the word that memory returned.

For a load, the block picks the addressed byte or halfword out of the memory word. It then widens the value to 32 bits. The opcode selects whether that widening copies the sign bit or fills with zeros. For a store, the block copies the low byte or low halfword of the source register onto every lane of the write word. It also raises the byte enables for the addressed lanes only. Lanes are big-endian: offset 0 is the most significant byte.

An access whose size does not fit its address alignment raises a flag and produces no enables. Every output is registered, so results appear one clock after the inputs.

Top module: `aln_core`

## Requirements
- R1: Opcode 0x20 (signed byte load) and opcode 0x21 (signed halfword load) put the selected value in the low bits of the load result. Every higher bit is a copy of the value's top bit.
- R2: Opcode 0x24 (unsigned byte load) and opcode 0x25 (unsigned halfword load) put the selected value in the low bits of the load result. Every higher bit is zero.
- R3: Byte lane selection is big-endian. Offset k selects memory bits [31-8k : 24-8k], so offset 0 gives bits 31..24 and offset 3 gives bits 7..0.
- R4: Halfword lane selection is big-endian. Offset 0 selects memory bits 31..16 and offset 2 selects bits 15..0.
- R5: Opcode 0x28 (byte store) writes the source's bits 7..0 to all four lanes of the write word. It drives exactly one byte enable, bit (3-k) for offset k, where enable bit 3 covers bits 31..24.
- R6: Opcode 0x29 (halfword store) writes the source's bits 15..0 to both halves of the write word. The byte enables are 4'b1100 at offset 0 and 4'b0011 at offset 2.
- R7: Opcode 0x23 (word load) returns the memory word unchanged. Opcode 0x2B (word store) writes the source unchanged with byte enables 4'b1111.
- R8: A halfword access with address bit 0 set, or a word access with nonzero low bits, raises the misalign flag. In that case the byte enables, the load result and the write word are all zero.
- R9: Any other opcode leaves every output at zero, including the misalign flag.
- R10: All outputs are zero during reset. Each result appears at the outputs on the first rising clock edge after its inputs are applied.
- R11: Stores leave the load result at zero, and loads leave the write word and byte enables at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 6 | Access opcode |
| addr_lo_i | input | 2 | Low bits of the effective address |
| mem_rdata_i | input | 32 | Word read from memory |
| st_src_i | input | 32 | Store source register value |
| ld_data_o | output | 32 | Aligned and extended load result |
| wr_data_o | output | 32 | Lane-replicated write word |
| byte_en_o | output | 4 | Per-lane write enables, bit 3 = bits 31..24 |
| misalign_o | output | 1 | Size and alignment disagree |

## Verification
A wrong decode or lane choice shows up in the very next cycle. The load result carries bits from the wrong lane, or its upper bits are filled with the wrong extension, or the enables name the wrong lanes. The bench drives random words with their top bits both set and clear across every offset, so a stale or swapped lane index is caught within a few accesses. The misalign gating is also checked at the ports, because an access that should have been suppressed shows nonzero enables or data.

// File: rtl/aln_pkg.sv
`timescale 1ns/1ps
package aln_pkg;
    localparam int DW    = 32;
    localparam int NB    = DW / 8;
    localparam int OFF_W = $clog2(NB);

    localparam logic [5:0] OP_LB  = 6'h20;
    localparam logic [5:0] OP_LH  = 6'h21;
    localparam logic [5:0] OP_LW  = 6'h23;
    localparam logic [5:0] OP_LBU = 6'h24;
    localparam logic [5:0] OP_LHU = 6'h25;
    localparam logic [5:0] OP_SB  = 6'h28;
    localparam logic [5:0] OP_SH  = 6'h29;
    localparam logic [5:0] OP_SW  = 6'h2B;

    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} size_e;

    typedef struct packed {
        logic  ld;
        logic  st;
        size_e size;
        logic  sext;
    } acc_t;

    typedef struct packed {
        logic [DW-1:0] ld_data;
        logic [DW-1:0] wr_data;
        logic [NB-1:0] be;
        logic          misalign;
    } out_t;
endpackage

// File: rtl/aln_decode.sv
`timescale 1ns/1ps
module aln_decode
    import aln_pkg::*;
(
    input  logic [5:0]       op_i,
    input  logic [OFF_W-1:0] addr_i,
    output acc_t             acc_o,
    output logic             misalign_o
);
    always_comb begin
        acc_o = '{ld: 1'b0, st: 1'b0, size: SZ_B, sext: 1'b0};
        unique case (op_i)
            OP_LB:   acc_o = '{ld: 1'b1, st: 1'b0, size: SZ_B, sext: 1'b1};
            OP_LH:   acc_o = '{ld: 1'b1, st: 1'b0, size: SZ_H, sext: 1'b1};
            OP_LW:   acc_o = '{ld: 1'b1, st: 1'b0, size: SZ_W, sext: 1'b0};
            OP_LBU:  acc_o = '{ld: 1'b1, st: 1'b0, size: SZ_B, sext: 1'b0};
            OP_LHU:  acc_o = '{ld: 1'b1, st: 1'b0, size: SZ_H, sext: 1'b0};
            OP_SB:   acc_o = '{ld: 1'b0, st: 1'b1, size: SZ_B, sext: 1'b0};
            OP_SH:   acc_o = '{ld: 1'b0, st: 1'b1, size: SZ_H, sext: 1'b0};
            OP_SW:   acc_o = '{ld: 1'b0, st: 1'b1, size: SZ_W, sext: 1'b0};
            default: ;
        endcase
    end

    // alignment rule: halfword needs even offset, word needs offset zero
    always_comb begin
        misalign_o = 1'b0;
        if (acc_o.ld || acc_o.st) begin
            if (acc_o.size == SZ_H) misalign_o = addr_i[0];
            if (acc_o.size == SZ_W) misalign_o = (addr_i != '0);
        end
    end
endmodule

// File: rtl/aln_load.sv
`timescale 1ns/1ps
module aln_load
    import aln_pkg::*;
(
    input  size_e            size_i,
    input  logic             sext_i,
    input  logic [OFF_W-1:0] addr_i,
    input  logic [DW-1:0]    word_i,
    output logic [DW-1:0]    data_o
);
    localparam int NH = NB / 2;

    logic [7:0]  lane_b [NB];
    logic [15:0] lane_h [NH];

    // big-endian lane numbering: lane 0 is the most significant
    for (genvar k = 0; k < NB; k++) begin : g_blane
        assign lane_b[k] = word_i[DW-1-8*k -: 8];
    end
    for (genvar j = 0; j < NH; j++) begin : g_hlane
        assign lane_h[j] = word_i[DW-1-16*j -: 16];
    end

    logic [7:0]  sel_b;
    logic [15:0] sel_h;
    assign sel_b = lane_b[addr_i];
    assign sel_h = lane_h[addr_i[OFF_W-1:1]];

    always_comb begin
        unique case (size_i)
            SZ_B:    data_o = {{(DW-8){sext_i & sel_b[7]}}, sel_b};
            SZ_H:    data_o = {{(DW-16){sext_i & sel_h[15]}}, sel_h};
            default: data_o = word_i;
        endcase
    end
endmodule

// File: rtl/aln_store.sv
`timescale 1ns/1ps
module aln_store
    import aln_pkg::*;
(
    input  size_e            size_i,
    input  logic [OFF_W-1:0] addr_i,
    input  logic [DW-1:0]    src_i,
    output logic [DW-1:0]    data_o,
    output logic [NB-1:0]    be_o
);
    logic [NB-1:0] be_b;
    logic [NB-1:0] be_h;

    for (genvar k = 0; k < NB; k++) begin : g_be
        assign be_b[NB-1-k] = (addr_i == OFF_W'(k));
        assign be_h[NB-1-k] = (addr_i[OFF_W-1:1] == (OFF_W-1)'(k / 2));
    end

    always_comb begin
        unique case (size_i)
            SZ_B: begin
                data_o = {NB{src_i[7:0]}};
                be_o   = be_b;
            end
            SZ_H: begin
                data_o = {(NB/2){src_i[15:0]}};
                be_o   = be_h;
            end
            default: begin
                data_o = src_i;
                be_o   = '1;
            end
        endcase
    end
endmodule

// File: rtl/aln_core.sv
`timescale 1ns/1ps
module aln_core
    import aln_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    op_i,
    input  logic [1:0]    addr_lo_i,
    input  logic [31:0]   mem_rdata_i,
    input  logic [31:0]   st_src_i,
    output logic [31:0]   ld_data_o,
    output logic [31:0]   wr_data_o,
    output logic [3:0]    byte_en_o,
    output logic          misalign_o
);
    acc_t          acc;
    logic          mis;
    logic [DW-1:0] ld_word;
    logic [DW-1:0] st_word;
    logic [NB-1:0] st_be;
    out_t          out_d, out_q;

    aln_decode i_dec (
        .op_i       (op_i),
        .addr_i     (addr_lo_i),
        .acc_o      (acc),
        .misalign_o (mis)
    );

    aln_load i_ld (
        .size_i (acc.size),
        .sext_i (acc.sext),
        .addr_i (addr_lo_i),
        .word_i (mem_rdata_i),
        .data_o (ld_word)
    );

    aln_store i_st (
        .size_i (acc.size),
        .addr_i (addr_lo_i),
        .src_i  (st_src_i),
        .data_o (st_word),
        .be_o   (st_be)
    );

    always_comb begin
        out_d          = '0;
        out_d.misalign = mis;
        if (!mis) begin
            if (acc.ld) out_d.ld_data = ld_word;
            if (acc.st) begin
                out_d.wr_data = st_word;
                out_d.be      = st_be;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ld_data_o  = out_q.ld_data;
    assign wr_data_o  = out_q.wr_data;
    assign byte_en_o  = out_q.be;
    assign misalign_o = out_q.misalign;

    assert_misalign_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (byte_en_o == '0 && ld_data_o == '0 && wr_data_o == '0));

    assert_be_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en_o inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000,
                          4'b0011, 4'b1100, 4'b1111});

    assert_signed_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_LB)
            |-> (ld_data_o[31:8] == {24{ld_data_o[7]}}));

    assert_unsigned_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_LHU) |-> (ld_data_o[31:16] == '0));

    assert_store_no_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en_o != '0) |-> (ld_data_o == '0 && !misalign_o));

    assert_sh_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_SH && !$past(addr_lo_i[0]))
            |-> ($countones(byte_en_o) == 2));
endmodule

// File: tb/test_aln_core.sv
`timescale 1ns/1ps
module test_aln_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op = '0;
    logic [1:0]  addr = '0;
    logic [31:0] rdata = '0;
    logic [31:0] src = '0;
    logic [31:0] ld_data, wr_data;
    logic [3:0]  be;
    logic        mis;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    aln_core i_aln_core (
        .clk(clk), .rst_n(rst_n), .op_i(op), .addr_lo_i(addr),
        .mem_rdata_i(rdata), .st_src_i(src),
        .ld_data_o(ld_data), .wr_data_o(wr_data),
        .byte_en_o(be), .misalign_o(mis)
    );

    typedef struct packed {
        logic [31:0] ld;
        logic [31:0] wr;
        logic [3:0]  be;
        logic        mis;
    } exp_t;

    function automatic exp_t model(logic [5:0] o, logic [1:0] a,
                                   logic [31:0] w, logic [31:0] s);
        exp_t e = '0;
        logic [7:0]  b = w[31 - 8*a -: 8];
        logic [15:0] h = a[1] ? w[15:0] : w[31:16];
        case (o)
            6'h20: e.ld = {{24{b[7]}}, b};
            6'h24: e.ld = {24'd0, b};
            6'h21: if (a[0]) e.mis = 1; else e.ld = {{16{h[15]}}, h};
            6'h25: if (a[0]) e.mis = 1; else e.ld = {16'd0, h};
            6'h23: if (a != 0) e.mis = 1; else e.ld = w;
            6'h28: begin e.wr = {4{s[7:0]}}; e.be = 4'b1000 >> a; end
            6'h29: if (a[0]) e.mis = 1;
                   else begin e.wr = {2{s[15:0]}}; e.be = a[1] ? 4'b0011 : 4'b1100; end
            6'h2B: if (a != 0) e.mis = 1;
                   else begin e.wr = s; e.be = 4'b1111; end
            default: ;
        endcase
        return e;
    endfunction

    function automatic string tag_of(logic [5:0] o, logic [1:0] a);
        exp_t e = model(o, a, '0, '0);
        if (e.mis) return "R8";
        case (o)
            6'h20: return "R1 R3";
            6'h21: return "R1 R4";
            6'h24: return "R2 R3";
            6'h25: return "R2 R4";
            6'h28: return "R5 R11";
            6'h29: return "R6 R11";
            6'h23, 6'h2B: return "R7 R11";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // apply at a falling edge, sample at the following falling edge (R10)
    task automatic access(logic [5:0] o, logic [1:0] a, logic [31:0] w, logic [31:0] s);
        exp_t e;
        string t;
        op = o; addr = a; rdata = w; src = s;
        e = model(o, a, w, s);
        t = tag_of(o, a);
        @(negedge clk);
        check(t, "ld_data", ld_data, e.ld);
        check(t, "wr_data", wr_data, e.wr);
        check(t, "byte_en", {28'd0, be}, {28'd0, e.be});
        check(t, "misalign", {31'd0, mis}, {31'd0, e.mis});
    endtask

    localparam logic [5:0] OPS [8] = '{6'h20, 6'h21, 6'h23, 6'h24,
                                       6'h25, 6'h28, 6'h29, 6'h2B};

    initial begin
        void'($urandom(32'd4242));
        op = 6'h20; rdata = 32'hFFFF_FFFF; src = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R10: outputs zero while reset held
        check("R10", "reset ld_data", ld_data, '0);
        check("R10", "reset wr_data", wr_data, '0);
        check("R10", "reset byte_en", {28'd0, be}, '0);
        check("R10", "reset misalign", {31'd0, mis}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        access(6'h20, 2'd0, 32'h80_11_22_7F, '0);   // R1 negative byte lane 0
        access(6'h24, 2'd0, 32'h80_11_22_7F, '0);   // R2 same byte unsigned
        access(6'h20, 2'd3, 32'h80_11_22_7F, '0);   // R3 lane 3 positive
        access(6'h21, 2'd2, 32'h1234_F00D, '0);     // R4 low half, negative
        access(6'h25, 2'd0, 32'hBEEF_0001, '0);     // R4 upper half unsigned
        access(6'h28, 2'd2, '0, 32'hAABB_CC5A);     // R5 only low byte stored
        access(6'h29, 2'd0, '0, 32'h1357_9BDF);     // R6
        access(6'h29, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R8 odd halfword
        access(6'h2B, 2'd2, '0, 32'hFFFF_FFFF);     // R8 word off 2
        access(6'h23, 2'd1, 32'hFFFF_FFFF, '0);     // R8 word load off 1
        access(6'h2B, 2'd0, 32'h0, 32'hDEAD_BEEF);  // R7
        access(6'h22, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R9 hole in map
        access(6'h00, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R9

        // R10: output holds previous value until the next rising edge
        op = 6'h2B; addr = 0; src = 32'h0102_0304;
        @(posedge clk);
        #1;
        check("R10", "after edge wr_data", wr_data, 32'h0102_0304);
        op = 6'h00;
        #1;
        check("R10", "between edges wr_data", wr_data, 32'h0102_0304);
        @(negedge clk);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] o;
            if ($urandom_range(9) == 0) o = 6'($urandom);
            else o = OPS[$urandom_range(7)];
            access(o, 2'($urandom), $urandom, $urandom);
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule